// File: doc/BRIEF.md
# SIMD Packed Equality Compare Unit

This block is one slice of a vector ALU. It takes two packed source vectors of up to 256 bits, splits them into lanes of a selected element size, and compares each lane pair. A lane whose two elements match turns into a lane of all ones in the result, and a lane that differs turns into all zeros. The resulting mask can then drive select, blend or branch logic further down the pipeline.

The operand width picks how much of the vector is compared: 64, 128 or 256 bits. Bits above the compared region come from the old destination value, or are cleared, depending on the width and on a merge-mode input. A 128-bit operation can either keep the upper destination bits (the legacy behaviour) or clear them (the extended-encoding behaviour). The unit sets no flags and raises no arithmetic exceptions. It accepts one operation per cycle, and its registered result appears one cycle after the operation is accepted.

Top module: `simd_eq_unit`

## Requirements
- R1: With elem_size = 0 (8-bit lanes) and op_width = 2 (256 bits), every result byte is 8'hFF when the matching bytes of src_a and src_b are equal, and 8'h00 when they differ.
- R2: With elem_size = 1 (16-bit lanes), each aligned 16-bit result lane is all ones only if both of its bytes match, and all zeros otherwise.
- R3: With elem_size = 2 (32-bit lanes), each aligned 32-bit result lane is all ones only if all four of its bytes match, and all zeros otherwise.
- R4: With elem_size = 3 (64-bit lanes) and op_width = 2, each aligned 64-bit result lane is all ones only if all eight of its bytes match, and all zeros otherwise.
- R5: With op_width = 0 (64 bits), only bits 63:0 are compared, and result bits 255:64 equal old_dst bits 255:64.
- R6: With op_width = 1 (128 bits) and keep_upper = 1, bits 127:0 are compared, and result bits 255:128 equal old_dst bits 255:128.
- R7: With op_width = 1 and keep_upper = 0, bits 127:0 are compared, and result bits 255:128 are zero.
- R8: With op_width = 2, both 128-bit halves are compared with the same element size, and keep_upper has no effect on the result.
- R9: Three combinations are illegal: elem_size = 3 together with op_width 0 or 1, and op_width = 3 with any element size. An illegal operation sets illegal_op to 1 and makes the result equal to old_dst. A legal operation sets illegal_op to 0.
- R10: out_valid is 1 exactly in the cycle after a cycle in which in_valid was 1. result and illegal_op update only for accepted operations and hold their values otherwise.
- R11: After a synchronous reset, out_valid, illegal_op and result are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Accept the operands presented in this cycle |
| src_a | input | 256 | First packed source vector |
| src_b | input | 256 | Second packed source vector |
| old_dst | input | 256 | Prior destination value, used for the bits that are kept |
| elem_size | input | 2 | Lane size: 0 = 8, 1 = 16, 2 = 32, 3 = 64 bits |
| op_width | input | 2 | Operand width: 0 = 64, 1 = 128, 2 = 256 bits, 3 = reserved |
| keep_upper | input | 1 | For 128-bit operations: 1 keeps the upper destination bits, 0 clears them |
| out_valid | output | 1 | Result valid, one cycle after acceptance |
| result | output | 256 | Registered mask result |
| illegal_op | output | 1 | The accepted operation used an illegal size and width combination |

## Verification
The bench builds the unit with its default 256-bit vector and 8-bit base lane. This setting brings every element size and every operand width into reach, including the 64-bit lane size and the reserved width code. A table of directed byte-difference patterns places mismatches at lane edges, inside a single lane and only above the compared region. The random phase then covers, at every size and width, the all-equal, none-equal and single-lane-differs cases, with the expected values taken from an independent lane-by-lane model.

// File: rtl/simd_eq_pkg.sv
package simd_eq_pkg;

    localparam int VEC_W  = 256;
    localparam int BYTE_W = 8;
    localparam int NBYTES = VEC_W / BYTE_W;
    localparam int NSIZES = 4;

    typedef enum logic [1:0] {
        ESZ_8  = 2'd0,
        ESZ_16 = 2'd1,
        ESZ_32 = 2'd2,
        ESZ_64 = 2'd3
    } elem_size_e;

    typedef enum logic [1:0] {
        OPW_64  = 2'd0,
        OPW_128 = 2'd1,
        OPW_256 = 2'd2,
        OPW_RSV = 2'd3
    } op_width_e;

    typedef struct packed {
        logic [VEC_W-1:0] data;
        logic             illegal;
    } eq_result_t;

    function automatic logic combo_illegal(elem_size_e sz, op_width_e w);
        return (w == OPW_RSV) || (sz == ESZ_64 && w != OPW_256);
    endfunction

endpackage

// File: rtl/simd_eq_bytecmp.sv
module simd_eq_bytecmp #(
    parameter int VEC_W  = 256,
    parameter int BYTE_W = 8,
    localparam int NB    = VEC_W / BYTE_W
) (
    input  logic [VEC_W-1:0] op_a,
    input  logic [VEC_W-1:0] op_b,
    output logic [NB-1:0]    byte_eq
);
    for (genvar i = 0; i < NB; i++) begin : g_byte
        assign byte_eq[i] = (op_a[i*BYTE_W +: BYTE_W] == op_b[i*BYTE_W +: BYTE_W]);
    end
endmodule

// File: rtl/simd_eq_lanemask.sv
module simd_eq_lanemask
    import simd_eq_pkg::*;
#(
    parameter int VEC_W  = 256,
    parameter int BYTE_W = 8,
    localparam int NB    = VEC_W / BYTE_W
) (
    input  logic [NB-1:0]    byte_eq,
    input  elem_size_e       size,
    output logic [VEC_W-1:0] mask
);
    // grp[k][i]: every byte of the aligned 2^k-byte group holding byte i matches
    logic [NSIZES-1:0][NB-1:0] grp;
    logic [NB-1:0]             sel;

    for (genvar k = 0; k < NSIZES; k++) begin : g_size
        localparam int G = 1 << k;
        for (genvar i = 0; i < NB; i++) begin : g_byte
            assign grp[k][i] = &byte_eq[(i / G) * G +: G];
        end
    end

    always_comb begin
        sel = grp[size];
    end

    for (genvar i = 0; i < NB; i++) begin : g_expand
        assign mask[i*BYTE_W +: BYTE_W] = {BYTE_W{sel[i]}};
    end
endmodule

// File: rtl/simd_eq_merge.sv
module simd_eq_merge
    import simd_eq_pkg::*;
#(
    parameter int VEC_W = 256,
    localparam int Q    = VEC_W / 4,
    localparam int H    = VEC_W / 2
) (
    input  logic [VEC_W-1:0] mask,
    input  logic [VEC_W-1:0] old_dst,
    input  elem_size_e       size,
    input  op_width_e        width,
    input  logic             keep_upper,
    output eq_result_t       res
);
    always_comb begin
        res.illegal = combo_illegal(size, width);
        res.data    = old_dst;
        if (!res.illegal) begin
            unique case (width)
                OPW_64:  res.data = {old_dst[VEC_W-1:Q], mask[Q-1:0]};
                OPW_128: res.data = {keep_upper ? old_dst[VEC_W-1:H] : {H{1'b0}}, mask[H-1:0]};
                default: res.data = mask;
            endcase
        end
    end
endmodule

// File: rtl/simd_eq_unit.sv
module simd_eq_unit
    import simd_eq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [VEC_W-1:0] src_a,
    input  logic [VEC_W-1:0] src_b,
    input  logic [VEC_W-1:0] old_dst,
    input  logic [1:0]       elem_size,
    input  logic [1:0]       op_width,
    input  logic             keep_upper,
    output logic             out_valid,
    output logic [VEC_W-1:0] result,
    output logic             illegal_op
);
    localparam int Q = VEC_W / 4;
    localparam int H = VEC_W / 2;

    elem_size_e       size_e;
    op_width_e        width_e;
    logic [NBYTES-1:0] byte_eq;
    logic [VEC_W-1:0] mask;
    eq_result_t       nxt;

    assign size_e  = elem_size_e'(elem_size);
    assign width_e = op_width_e'(op_width);

    simd_eq_bytecmp #(.VEC_W(VEC_W), .BYTE_W(BYTE_W)) u_cmp (
        .op_a(src_a), .op_b(src_b), .byte_eq(byte_eq)
    );

    simd_eq_lanemask #(.VEC_W(VEC_W), .BYTE_W(BYTE_W)) u_mask (
        .byte_eq(byte_eq), .size(size_e), .mask(mask)
    );

    simd_eq_merge #(.VEC_W(VEC_W)) u_merge (
        .mask(mask), .old_dst(old_dst), .size(size_e), .width(width_e),
        .keep_upper(keep_upper), .res(nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            result     <= '0;
            illegal_op <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result     <= nxt.data;
                illegal_op <= nxt.illegal;
            end
        end
    end

    // R10: strobe follows acceptance by one cycle
    p_valid_follows_r10: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    p_valid_idle_r10: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(result) && $stable(illegal_op)));

    // R9: illegal combinations flag and pass the old destination through
    p_illegal_keeps_dst_r9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (op_width == 2'd3 || (elem_size == 2'd3 && op_width != 2'd2)))
        |=> (illegal_op && result == $past(old_dst)));

    // R8: full width is legal for all sizes
    p_wide_legal_r8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_width == 2'd2) |=> !illegal_op);

    // R5: 64-bit width keeps bits above the low quarter
    p_narrow_upper_kept_r5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_width == 2'd0 && elem_size != 2'd3)
        |=> (result[VEC_W-1:Q] == $past(old_dst[VEC_W-1:Q])));

    // R6: legacy 128-bit keeps the upper half
    p_legacy_upper_kept_r6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_width == 2'd1 && elem_size != 2'd3 && keep_upper)
        |=> (result[VEC_W-1:H] == $past(old_dst[VEC_W-1:H])));

    // R7: extended 128-bit clears the upper half
    p_ext_upper_zero_r7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_width == 2'd1 && elem_size != 2'd3 && !keep_upper)
        |=> (result[VEC_W-1:H] == '0));
endmodule

// File: tb/tb_simd_eq_unit.sv
`timescale 1ns/1ps
module tb_simd_eq_unit;
    localparam int W = 256;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [W-1:0] src_a = '0, src_b = '0, old_dst = '0;
    logic [1:0]   elem_size = '0, op_width = '0;
    logic         keep_upper = 1'b0;
    logic         out_valid, illegal_op;
    logic [W-1:0] result;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    simd_eq_unit dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .src_a(src_a), .src_b(src_b),
        .old_dst(old_dst), .elem_size(elem_size), .op_width(op_width),
        .keep_upper(keep_upper), .out_valid(out_valid), .result(result),
        .illegal_op(illegal_op)
    );

    // {elem_size, op_width, keep_upper, byte-difference mask}
    localparam logic [36:0] TBL [13] = '{
        {2'd0, 2'd2, 1'b0, 32'h0000_0000},
        {2'd0, 2'd2, 1'b0, 32'hFFFF_FFFF},
        {2'd0, 2'd2, 1'b0, 32'h8000_0001},
        {2'd1, 2'd2, 1'b0, 32'h0000_0004},
        {2'd2, 2'd2, 1'b1, 32'h0100_0000},
        {2'd3, 2'd2, 1'b0, 32'h0000_0100},
        {2'd0, 2'd0, 1'b1, 32'h0000_0010},
        {2'd2, 2'd0, 1'b0, 32'hFF00_0000},
        {2'd1, 2'd1, 1'b1, 32'h0000_8000},
        {2'd1, 2'd1, 1'b0, 32'h0001_0000},
        {2'd3, 2'd1, 1'b0, 32'h0000_0000},
        {2'd3, 2'd0, 1'b1, 32'h0000_0000},
        {2'd0, 2'd3, 1'b0, 32'h0000_0000}
    };

    function automatic logic [W:0] model(logic [W-1:0] a, logic [W-1:0] b, logic [W-1:0] od,
                                         logic [1:0] sz, logic [1:0] wd, logic kp);
        logic [W-1:0] r;
        logic ill;
        int nbytes, lb;
        ill = (wd == 2'd3) || (sz == 2'd3 && wd != 2'd2);
        r = od;
        if (!ill) begin
            nbytes = (64 << wd) / 8;
            lb = 1 << sz;
            if (wd == 2'd1 && !kp) r[W-1:128] = '0;
            for (int l = 0; l < nbytes / lb; l++) begin
                logic eq;
                eq = 1'b1;
                for (int k = 0; k < lb; k++)
                    if (a[(l*lb+k)*8 +: 8] != b[(l*lb+k)*8 +: 8]) eq = 1'b0;
                for (int k = 0; k < lb; k++)
                    r[(l*lb+k)*8 +: 8] = {8{eq}};
            end
        end
        return {ill, r};
    endfunction

    function automatic string tag_of(logic [1:0] sz, logic [1:0] wd, logic kp);
        if (wd == 2'd3 || (sz == 2'd3 && wd != 2'd2)) return "R9";
        if (wd == 2'd0) return "R5";
        if (wd == 2'd1) return kp ? "R6" : "R7";
        case (sz)
            2'd0: return "R1";
            2'd1: return "R2";
            2'd2: return "R3";
            default: return "R4";
        endcase
    endfunction

    task automatic check(string tag, logic [W-1:0] got, logic [W-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    // drive at negedge, sample at the following negedge (one register)
    task automatic run_op(logic [W-1:0] a, logic [W-1:0] b, logic [W-1:0] od,
                          logic [1:0] sz, logic [1:0] wd, logic kp, string tag);
        logic [W:0] e;
        src_a = a; src_b = b; old_dst = od;
        elem_size = sz; op_width = wd; keep_upper = kp; in_valid = 1'b1;
        e = model(a, b, od, sz, wd, kp);
        @(negedge clk);
        in_valid = 1'b0;
        check({tag, " R10 valid"}, W'(out_valid), W'(1));
        check({tag, " result"}, result, e[W-1:0]);
        check({tag, " illegal"}, W'(illegal_op), W'(e[W]));
    endtask

    function automatic logic [W-1:0] rand_vec();
        logic [W-1:0] v;
        for (int i = 0; i < W / 32; i++) v[i*32 +: 32] = $urandom;
        return v;
    endfunction

    initial begin
        logic [W-1:0] a, b, od, held;
        @(negedge clk);
        @(negedge clk);
        check("R11 out_valid", W'(out_valid), W'(0));
        check("R11 result", result, '0);
        check("R11 illegal", W'(illegal_op), W'(0));
        rst = 1'b0;
        @(negedge clk);

        // table walk
        for (int t = 0; t < 13; t++) begin
            logic [36:0] e;
            e = TBL[t];
            a = {8{32'hA5C3_1E70}} ^ {W/64{64'h0123_4567_89AB_CDEF}};
            b = a;
            for (int i = 0; i < 32; i++) if (e[i]) b[i*8 +: 8] = b[i*8 +: 8] ^ 8'h5A;
            od = {8{32'hDEAD_BEEF}};
            run_op(a, b, od, e[36:35], e[34:33], e[32], tag_of(e[36:35], e[34:33], e[32]));
        end

        // R10: idle cycle holds result and illegal flag, strobe low
        held = result;
        src_a = rand_vec(); src_b = ~src_a; old_dst = rand_vec();
        op_width = 2'd2; elem_size = 2'd0;
        @(negedge clk);
        check("R10 idle valid", W'(out_valid), W'(0));
        check("R10 idle hold", result, held);
        check("R10 idle illegal hold", W'(illegal_op), W'(1));

        // R8: keep_upper has no effect at full width
        a = rand_vec(); b = a; b[200 +: 8] = ~b[200 +: 8]; od = rand_vec();
        run_op(a, b, od, 2'd1, 2'd2, 1'b0, "R8 keep0");
        held = result;
        run_op(a, b, od, 2'd1, 2'd2, 1'b1, "R8 keep1");
        check("R8 keep no effect", result, held);

        // R9: illegal then legal clears flag
        run_op(a, a, od, 2'd3, 2'd3, 1'b1, "R9 rsv width");
        run_op(a, a, od, 2'd3, 2'd2, 1'b1, "R9 legal after");

        // R10: back-to-back operations
        run_op(a, a, od, 2'd0, 2'd2, 1'b0, "R10 b2b first");
        run_op(a, ~a, od, 2'd0, 2'd2, 1'b0, "R10 b2b second");

        // random: every size, width, keep and pattern mode
        for (int it = 0; it < 4; it++)
            for (int sz = 0; sz < 4; sz++)
                for (int wd = 0; wd < 4; wd++)
                    for (int kp = 0; kp < 2; kp++)
                        for (int md = 0; md < 4; md++) begin
                            a = rand_vec(); od = rand_vec();
                            case (md)
                                0: b = a;
                                1: b = ~a;
                                2: begin
                                    b = a;
                                    b[($urandom % 32) * 8 +: 8] ^= 8'h01;
                                end
                                default: begin
                                    b = rand_vec();
                                    for (int i = 0; i < 32; i++)
                                        if ($urandom % 2) b[i*8 +: 8] = a[i*8 +: 8];
                                end
                            endcase
                            run_op(a, b, od, 2'(sz), 2'(wd), 1'(kp),
                                   tag_of(2'(sz), 2'(wd), 1'(kp)));
                        end

        // R11: reset clears registered state
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R11 reset result", result, '0);
        check("R11 reset valid", W'(out_valid), W'(0));
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #500000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule